// File: doc/BRIEF.md
# Fixed-Point RGB Line Convolution Engine

This block applies a square, odd-sized filter kernel to 24-bit RGB image lines and produces one filtered output line per run. A circular store of up to `MAX_FILTER` image lines is written through a pixel port. A kernel of up to `MAX_FILTER` by `MAX_FILTER` signed fixed-point coefficients is loaded one value at a time. Each run starts with a pulse that carries the kernel size, the image width and the index of the buffered line that lines up with kernel row 0.

The three colour channels are filtered on their own, all with the same coefficients. Each channel keeps a 16-bit Q9.7 accumulator that saturates. The engine handles one multiply-accumulate tap per clock for all three channels together. It emits the magnitude of each channel sum as an 8-bit value, with one valid-qualified pixel per output column, and pulses done after the last column.

Top module: `rgb_line_conv`

## Requirements
- R1: After reset, and until the first accepted start, `pix_valid_o` and `done_o` are low.
- R2: Coefficients are two's-complement Q9.7: the value is the 16-bit word divided by 128. Each coefficient is written on its own at index m*size+n, where m is the kernel row and n is the kernel column.
- R3: Pixels pack red in bits [23:16], green in [15:8] and blue in [7:0]. Each channel is filtered independently with the same coefficient set.
- R4: For output column p, kernel column n reads input column p+n-size/2. A tap whose column is negative or at or above the width adds nothing to the accumulator.
- R5: Kernel row 0 reads line `top_i`. Each later row reads the next line index, and index `MAX_FILTER`-1 is followed by 0.
- R6: For each output pixel the accumulator starts at 0. Taps are added with n as the inner loop and m as the outer loop. Each product (pixel times coefficient, in units of 1/128) is added and the result is clamped to [-32768, 32767] after every tap.
- R7: Each output channel equals the accumulator's absolute value shifted right by 7 bits, limited to 255.
- R8: `ksize_i`, `width_i` and `top_i` are captured when start is accepted in idle. Output column p appears exactly (p+1)*size*size+2 cycles after that start edge. There is one pixel per column, in column order.
- R9: `done_o` is high for exactly one cycle, the cycle after the pixel of column width-1.
- R10: A start pulse, or a change of size, width or top index, while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_idx_i | input | KW | Coefficient index m*size+n |
| coef_val_i | input | 16 | Q9.7 coefficient |
| line_we_i | input | 1 | Line-store write strobe |
| line_sel_i | input | LW | Line index for write |
| line_col_i | input | CW | Column for write |
| line_pix_i | input | 24 | RGB pixel to write |
| start_i | input | 1 | Start a run (sampled in idle) |
| ksize_i | input | SW | Odd kernel size, 1..MAX_FILTER |
| top_i | input | LW | Line index of kernel row 0 |
| width_i | input | WW | Image width, 1..MAX_WIDTH |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 24 | Output RGB magnitude pixel |
| done_o | output | 1 | One-cycle end-of-line pulse |

## Verification
Directed kernels with a single unit tap (centre, last row after a wrap, corner) show that each tap reads the right line and column, and that edge columns are skipped rather than read from a neighbour. Negative and half-unit gains separate taking the magnitude from passing the sign through, and show that the fraction is truncated. Full-scale coefficients, and a saturate-then-subtract pattern, tell per-tap clamping apart from a wide sum clamped only at the end. Random sizes, widths, top indices and pixels cover channel independence. A run with start pulsed and the run settings changed mid-line shows that they are held while the run is busy.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int PIX_W  = 8;
  localparam int CH_N   = 3;
  localparam int COEF_W = 16;
  localparam int FRAC_W = 7;

  typedef logic signed [COEF_W-1:0] q9_7_t;
  typedef logic [PIX_W-1:0]         chan_t;
  typedef logic [CH_N*PIX_W-1:0]    rgb_t;
endpackage

// File: rtl/conv_coef_store.sv
module conv_coef_store import conv_pkg::*; #(
  parameter int DEPTH = 25,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  q9_7_t         wr_val_i,
  input  logic [AW-1:0] rd_idx_i,
  output q9_7_t         rd_val_o
);
  q9_7_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && (int'(wr_idx_i) < DEPTH)) mem[wr_idx_i] <= wr_val_i;
    rd_val_o <= mem[rd_idx_i];
  end
endmodule

// File: rtl/conv_line_buf.sv
module conv_line_buf import conv_pkg::*; #(
  parameter int LINES = 5,
  parameter int DEPTH = 64,
  localparam int LW = $clog2(LINES),
  localparam int CW = $clog2(DEPTH)
)(
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [LW-1:0] wr_line_i,
  input  logic [CW-1:0] wr_col_i,
  input  rgb_t          wr_pix_i,
  input  logic [LW-1:0] rd_line_i,
  input  logic [CW-1:0] rd_col_i,
  output rgb_t          rd_pix_o
);
  rgb_t mem [LINES][DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && (int'(wr_line_i) < LINES)) mem[wr_line_i][wr_col_i] <= wr_pix_i;
    rd_pix_o <= mem[rd_line_i][rd_col_i];
  end
endmodule

// File: rtl/conv_tap_seq.sv
module conv_tap_seq #(
  parameter int MAX_FILTER = 5,
  parameter int MAX_WIDTH  = 64,
  localparam int LW = $clog2(MAX_FILTER),
  localparam int CW = $clog2(MAX_WIDTH),
  localparam int SW = $clog2(MAX_FILTER + 1),
  localparam int WW = $clog2(MAX_WIDTH + 1),
  localparam int KW = $clog2(MAX_FILTER * MAX_FILTER)
)(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] ksize_i,
  input  logic [LW-1:0] top_i,
  input  logic [WW-1:0] width_i,
  output logic          tap_valid_o,
  output logic          tap_first_o,
  output logic          tap_last_o,
  output logic          tap_eol_o,
  output logic          tap_inr_o,
  output logic [LW-1:0] tap_line_o,
  output logic [CW-1:0] tap_col_o,
  output logic [KW-1:0] tap_cidx_o
);
  localparam int XW = ((CW > SW) ? CW : SW) + 2;

  logic          run_q;
  logic [SW-1:0] size_q, ctr_q, m_q, n_q;
  logic [LW-1:0] top_q, line_q;
  logic [WW-1:0] width_q;
  logic [CW-1:0] p_q;
  logic [KW-1:0] cidx_q;

  logic n_last, m_last, p_last, inr;
  logic signed [XW-1:0] col_s;

  always_comb begin
    n_last = (n_q == size_q - SW'(1));
    m_last = (m_q == size_q - SW'(1));
    p_last = (WW'(p_q) == width_q - WW'(1));
    col_s  = $signed(XW'(p_q)) + $signed(XW'(n_q)) - $signed(XW'(ctr_q));
    inr    = !col_s[XW-1] && (col_s < $signed(XW'(width_q)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      size_q      <= '0;
      ctr_q       <= '0;
      m_q         <= '0;
      n_q         <= '0;
      top_q       <= '0;
      line_q      <= '0;
      width_q     <= '0;
      p_q         <= '0;
      cidx_q      <= '0;
      tap_valid_o <= 1'b0;
      tap_first_o <= 1'b0;
      tap_last_o  <= 1'b0;
      tap_eol_o   <= 1'b0;
      tap_inr_o   <= 1'b0;
      tap_line_o  <= '0;
      tap_col_o   <= '0;
      tap_cidx_o  <= '0;
    end else begin
      tap_valid_o <= run_q;
      if (run_q) begin
        tap_first_o <= (m_q == '0) && (n_q == '0);
        tap_last_o  <= n_last && m_last;
        tap_eol_o   <= n_last && m_last && p_last;
        tap_inr_o   <= inr;
        tap_line_o  <= line_q;
        tap_col_o   <= inr ? col_s[CW-1:0] : '0;
        tap_cidx_o  <= cidx_q;
        if (n_last) begin
          n_q <= '0;
          if (m_last) begin
            m_q    <= '0;
            line_q <= top_q;
            cidx_q <= '0;
            if (p_last) run_q <= 1'b0;
            else        p_q   <= p_q + CW'(1);
          end else begin
            m_q    <= m_q + SW'(1);
            line_q <= (line_q == LW'(MAX_FILTER - 1)) ? '0 : line_q + LW'(1);
            cidx_q <= cidx_q + KW'(1);
          end
        end else begin
          n_q    <= n_q + SW'(1);
          cidx_q <= cidx_q + KW'(1);
        end
      end else if (start_i) begin
        run_q   <= 1'b1;
        size_q  <= ksize_i;
        ctr_q   <= ksize_i >> 1;
        top_q   <= top_i;
        line_q  <= top_i;
        width_q <= width_i;
        p_q     <= '0;
        m_q     <= '0;
        n_q     <= '0;
        cidx_q  <= '0;
      end
    end
  end

  assert_line_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_valid_o |-> (int'(tap_line_o) < MAX_FILTER));
  assert_row0_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_valid_o && tap_first_o |-> tap_line_o == top_q);
  assert_col_inside_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_valid_o && tap_inr_o |-> (WW'(tap_col_o) < width_q));
  assert_first_idx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_valid_o && tap_first_o |-> tap_cidx_o == '0);
  assert_hold_cfg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && start_i |=> $stable(size_q) && $stable(width_q) && $stable(top_q));
endmodule

// File: rtl/conv_mac.sv
module conv_mac import conv_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  first_i,
  input  logic  last_i,
  input  logic  inr_i,
  input  chan_t pix_i,
  input  q9_7_t coef_i,
  output logic  out_valid_o,
  output chan_t out_o
);
  localparam int PW = COEF_W + PIX_W + 1;
  localparam int IW = COEF_W + 1 - FRAC_W;
  localparam logic signed [PW-1:0] SAT_HI = PW'((2 ** (COEF_W - 1)) - 1);
  localparam logic signed [PW-1:0] SAT_LO = ~SAT_HI;

  q9_7_t acc_q;
  logic signed [PW-1:0] base, prod, sum;
  q9_7_t sat;
  logic [COEF_W:0] ext, mag;
  logic [IW-1:0] ipart;
  chan_t clamped;

  always_comb begin
    base = first_i ? '0 : {{(PW-COEF_W){acc_q[COEF_W-1]}}, acc_q};
    if (inr_i)
      prod = $signed({{(PW-PIX_W){1'b0}}, pix_i}) *
             $signed({{(PW-COEF_W){coef_i[COEF_W-1]}}, coef_i});
    else
      prod = '0;
    sum = base + prod;
    if (sum > SAT_HI)      sat = SAT_HI[COEF_W-1:0];
    else if (sum < SAT_LO) sat = SAT_LO[COEF_W-1:0];
    else                   sat = sum[COEF_W-1:0];
    ext     = {sat[COEF_W-1], sat};
    mag     = ext[COEF_W] ? (~ext + 1'b1) : ext;
    ipart   = mag[COEF_W:FRAC_W];
    clamped = (|ipart[IW-1:PIX_W]) ? '1 : ipart[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      out_valid_o <= 1'b0;
      out_o       <= '0;
    end else begin
      if (en_i) acc_q <= sat;
      out_valid_o <= en_i && last_i;
      if (en_i && last_i) out_o <= clamped;
    end
  end

  assert_skip_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && first_i && !inr_i |=> acc_q == '0);
  assert_skip_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !first_i && !inr_i |=> acc_q == $past(acc_q));
endmodule

// File: rtl/rgb_line_conv.sv
module rgb_line_conv import conv_pkg::*; #(
  parameter int MAX_FILTER = 5,
  parameter int MAX_WIDTH  = 64,
  localparam int LW = $clog2(MAX_FILTER),
  localparam int CW = $clog2(MAX_WIDTH),
  localparam int SW = $clog2(MAX_FILTER + 1),
  localparam int WW = $clog2(MAX_WIDTH + 1),
  localparam int KW = $clog2(MAX_FILTER * MAX_FILTER)
)(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  coef_we_i,
  input  logic [KW-1:0]         coef_idx_i,
  input  logic [COEF_W-1:0]     coef_val_i,
  input  logic                  line_we_i,
  input  logic [LW-1:0]         line_sel_i,
  input  logic [CW-1:0]         line_col_i,
  input  logic [CH_N*PIX_W-1:0] line_pix_i,
  input  logic                  start_i,
  input  logic [SW-1:0]         ksize_i,
  input  logic [LW-1:0]         top_i,
  input  logic [WW-1:0]         width_i,
  output logic                  pix_valid_o,
  output logic [CH_N*PIX_W-1:0] pix_o,
  output logic                  done_o
);
  logic          tap_valid, tap_first, tap_last, tap_eol, tap_inr;
  logic [LW-1:0] tap_line;
  logic [CW-1:0] tap_col;
  logic [KW-1:0] tap_cidx;
  rgb_t          rd_pix;
  q9_7_t         rd_coef;

  logic s1_valid_q, s1_first_q, s1_last_q, s1_inr_q, s1_eol_q, s2_eol_q;
  logic [CH_N-1:0] ch_valid;

  conv_tap_seq #(.MAX_FILTER(MAX_FILTER), .MAX_WIDTH(MAX_WIDTH)) u_seq (
    .clk_i, .rst_ni, .start_i, .ksize_i, .top_i, .width_i,
    .tap_valid_o(tap_valid), .tap_first_o(tap_first), .tap_last_o(tap_last),
    .tap_eol_o(tap_eol), .tap_inr_o(tap_inr), .tap_line_o(tap_line),
    .tap_col_o(tap_col), .tap_cidx_o(tap_cidx)
  );

  conv_coef_store #(.DEPTH(MAX_FILTER * MAX_FILTER)) u_coef (
    .clk_i, .wr_en_i(coef_we_i), .wr_idx_i(coef_idx_i), .wr_val_i(q9_7_t'(coef_val_i)),
    .rd_idx_i(tap_cidx), .rd_val_o(rd_coef)
  );

  conv_line_buf #(.LINES(MAX_FILTER), .DEPTH(MAX_WIDTH)) u_lines (
    .clk_i, .wr_en_i(line_we_i), .wr_line_i(line_sel_i), .wr_col_i(line_col_i),
    .wr_pix_i(line_pix_i), .rd_line_i(tap_line), .rd_col_i(tap_col), .rd_pix_o(rd_pix)
  );

  // tap flags follow the registered memory reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_first_q <= 1'b0;
      s1_last_q  <= 1'b0;
      s1_inr_q   <= 1'b0;
      s1_eol_q   <= 1'b0;
      s2_eol_q   <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      s1_valid_q <= tap_valid;
      s1_first_q <= tap_first;
      s1_last_q  <= tap_last;
      s1_inr_q   <= tap_inr;
      s1_eol_q   <= tap_eol;
      s2_eol_q   <= s1_valid_q && s1_eol_q;
      done_o     <= s2_eol_q;
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    conv_mac u_mac (
      .clk_i, .rst_ni,
      .en_i(s1_valid_q), .first_i(s1_first_q), .last_i(s1_last_q), .inr_i(s1_inr_q),
      .pix_i(rd_pix[c*PIX_W +: PIX_W]), .coef_i(rd_coef),
      .out_valid_o(ch_valid[c]), .out_o(pix_o[c*PIX_W +: PIX_W])
    );
  end

  assign pix_valid_o = &ch_valid;

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(pix_valid_o));
endmodule

// File: tb/rgb_line_conv_test.sv
`timescale 1ns/1ps
module rgb_line_conv_test;
  localparam int MAXF = 5;
  localparam int MAXW = 64;
  localparam int LW = $clog2(MAXF);
  localparam int CW = $clog2(MAXW);
  localparam int SW = $clog2(MAXF + 1);
  localparam int WW = $clog2(MAXW + 1);
  localparam int KW = $clog2(MAXF * MAXF);

  logic clk = 0, rst_n = 0;
  logic coef_we = 0; logic [KW-1:0] coef_idx = '0; logic [15:0] coef_val = '0;
  logic line_we = 0; logic [LW-1:0] line_sel = '0; logic [CW-1:0] line_col = '0;
  logic [23:0] line_pix = '0;
  logic start = 0; logic [SW-1:0] ksize = '0; logic [LW-1:0] top_sel = '0;
  logic [WW-1:0] width = '0;
  logic pix_valid, done;
  logic [23:0] pix;

  int n_tests = 0, n_fail = 0;
  logic [23:0] img [MAXF][MAXW];
  int cf [MAXF*MAXF];

  always #4 clk = ~clk;

  rgb_line_conv #(.MAX_FILTER(MAXF), .MAX_WIDTH(MAXW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .coef_we_i(coef_we), .coef_idx_i(coef_idx), .coef_val_i(coef_val),
    .line_we_i(line_we), .line_sel_i(line_sel), .line_col_i(line_col), .line_pix_i(line_pix),
    .start_i(start), .ksize_i(ksize), .top_i(top_sel), .width_i(width),
    .pix_valid_o(pix_valid), .pix_o(pix), .done_o(done)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] model_pix(int p, int sz, int top, int w);
    logic [23:0] r = '0;
    for (int ch = 0; ch < 3; ch++) begin
      int acc = 0;
      int ln = top;
      int mag, v;
      for (int m = 0; m < sz; m++) begin
        for (int n = 0; n < sz; n++) begin
          int c = p + n - sz / 2;
          if (c >= 0 && c < w) acc += int'(img[ln][c][ch*8 +: 8]) * cf[m*sz + n];
          if (acc > 32767) acc = 32767;
          if (acc < -32768) acc = -32768;
        end
        ln = (ln + 1 == MAXF) ? 0 : ln + 1;
      end
      mag = (acc < 0) ? -acc : acc;
      v = mag >> 7;
      if (v > 255) v = 255;
      r[ch*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  task automatic set_coef(int i, int v);
    cf[i] = v;
    coef_we = 1; coef_idx = KW'(i); coef_val = 16'(v);
    @(negedge clk);
    coef_we = 0;
  endtask

  task automatic clear_coefs();
    for (int i = 0; i < MAXF*MAXF; i++) set_coef(i, 0);
  endtask

  task automatic rand_coefs(int lim);
    for (int i = 0; i < MAXF*MAXF; i++) set_coef(i, int'($urandom_range(2*lim)) - lim);
  endtask

  task automatic fill_lines(bit full);
    for (int l = 0; l < MAXF; l++)
      for (int c = 0; c < MAXW; c++) begin
        img[l][c] = full ? 24'hFFFFFF : 24'($urandom);
        line_we = 1; line_sel = LW'(l); line_col = CW'(c); line_pix = img[l][c];
        @(negedge clk);
      end
    line_we = 0;
  endtask

  task automatic do_run(int sz, int top, int w, bit poke, string req);
    int cyc = 0, got = 0;
    bit fin = 0;
    logic [23:0] exp;
    ksize = SW'(sz); top_sel = LW'(top); width = WW'(w); start = 1;
    @(negedge clk);
    start = 0;
    // settings changed after start must not matter (R10)
    ksize = SW'(3); top_sel = LW'((top + 1) % MAXF); width = WW'(2);
    while (!fin && cyc < 4000) begin
      if (pix_valid) begin
        exp = (got < w) ? model_pix(got, sz, top, w) : 24'h0;
        check(got < w && pix === exp, req, $sformatf("pixel %0d", got), pix, exp);
        check(cyc == (got + 1) * sz * sz + 2, "R8", $sformatf("pixel %0d cycle", got),
              cyc, (got + 1) * sz * sz + 2);
        got++;
      end
      if (done) begin
        fin = 1;
        check(cyc == w * sz * sz + 3, "R9", "done cycle", cyc, w * sz * sz + 3);
        check(got == w, "R8", "pixel count", got, w);
      end
      start = poke && (cyc == 4);
      @(negedge clk);
      cyc++;
    end
    start = 0;
    if (!fin) check(0, "R9", "done missing", 0, 1);
    repeat (4) begin
      check(!pix_valid && !done, "R10", "idle after run", {pix_valid, done}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "R8", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check(!pix_valid && !done, "R1", "in reset", {pix_valid, done}, 0);
    rst_n = 1;
    repeat (4) begin
      @(negedge clk);
      check(!pix_valid && !done, "R1", "after reset", {pix_valid, done}, 0);
    end

    fill_lines(0);
    // R2: centre unit tap reads the middle row, same column
    clear_coefs(); set_coef(4, 128);
    do_run(3, 0, 16, 0, "R2");
    // R5: last kernel row after wrap (3,4,0,1,2) -> line 2
    clear_coefs(); set_coef(22, 128);
    do_run(5, 3, 10, 0, "R5");
    // R4: corner taps reach outside the line at both edges
    clear_coefs(); set_coef(0, 128); set_coef(8, -128);
    do_run(3, 2, 12, 0, "R4");
    rand_coefs(300);
    do_run(5, 1, 1, 0, "R4");
    // R7: negative gain, then a half gain that truncates
    clear_coefs(); set_coef(0, -256);
    do_run(1, 4, 20, 0, "R7");
    set_coef(0, -64);
    do_run(1, 0, 20, 0, "R7");
    // R6: full-scale saturation, then saturate followed by subtract
    fill_lines(1);
    for (int i = 0; i < MAXF*MAXF; i++) set_coef(i, 32767);
    do_run(5, 0, 8, 0, "R6");
    fill_lines(0);
    clear_coefs(); set_coef(1, 32767); set_coef(2, -128); set_coef(4, -32768); set_coef(5, 128);
    do_run(3, 1, 16, 0, "R6");
    // R3: random channels, sizes, tops and widths
    for (int k = 0; k < 10; k++) begin
      int sz = 2 * int'($urandom_range(2)) + 1;
      rand_coefs(320);
      do_run(sz, int'($urandom_range(MAXF - 1)), 1 + int'($urandom_range(MAXW - 1)), 0, "R3");
    end
    do_run(5, 4, MAXW, 0, "R3");
    // R10: start pulsed mid-run
    rand_coefs(200);
    do_run(5, 2, 40, 1, "R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule